// File: doc/BRIEF.md
# Three-Way Fixed-Priority Resource Arbiter

This block decides which of three clients may use one shared resource. Each client raises its bit of `req` to ask for the resource. The arbiter answers through the matching bit of `gnt`. Internally it is a four-state Moore machine: one state for "nobody owns it" and one ownership state per client. The grant pins come only from the registered state, so there is no combinational path from `req` to `gnt`.

While no client owns the resource, the arbiter chooses by a fixed order. Client 0 ranks highest, then client 1, then client 2. Once a client wins, it keeps the resource for as long as its own request stays high. A higher-ranked request that arrives later does not take the resource away. When the owner drops its request, the machine always goes back to the free state for at least one cycle before it grants again. Control pins are plain levels; there is no streamed data.

Top module: `req_arbiter3`

## Requirements
- R1: An active-high `rst` clears all grants at once, without waiting for a clock edge, and leaves the arbiter in the free state.
- R2: In the free state, if `req[0]` is 1 at a rising edge, then after that edge `gnt` is 3'b001, whatever `req[2:1]` are.
- R3: In the free state, if `req[0]` is 0 and `req[1]` is 1 at a rising edge, then after that edge `gnt` is 3'b010.
- R4: In the free state, if `req` is 3'b100 at a rising edge, then after that edge `gnt` is 3'b100.
- R5: In the free state, if `req` is 3'b000 at a rising edge, then `gnt` stays 3'b000.
- R6: A client that holds the grant keeps it on every edge where its own `req` bit is 1, for any length of hold.
- R7: When the owner's `req` bit is 0 at an edge, `gnt` becomes 3'b000 for that next cycle, even if other requests are pending. No grant passes directly from one client to another.
- R8: A request from a higher-ranked client does not take the grant away from a lower-ranked client that holds it.
- R9: At most one bit of `gnt` is 1 at any time.
- R10: `gnt` changes only at a rising clock edge or on reset. A change on `req` between edges leaves `gnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| req | input | 3 | Request per client; bit 0 has the highest rank |
| gnt | output | 3 | Grant per client; at most one bit set |

## Verification
The bench goes after the rank order while the arbiter is free, by offering every mix of requests. If the priority chain were wrong, a lower-ranked client would win. It holds a grant for tens of cycles while the other requests toggle. A wrong hold condition would drop the grant early, or hand it to a higher-ranked client, which is preemption. It releases the owner while other requests are still pending. A design with a shortcut handoff would skip the free cycle. The bench also changes `req` between clock edges and pulses reset in mid-grant. A Mealy-style output would then glitch, and a synchronous reset would leave a grant standing until the next clock edge.

// File: rtl/arb3_pkg.sv
package arb3_pkg;
  localparam int unsigned NUM_CLIENTS = 3;
  localparam int unsigned STATE_W     = $clog2(NUM_CLIENTS + 1);

  // Code 0 is the free state; code k+1 means client k owns the resource.
  typedef enum logic [STATE_W-1:0] {
    ST_FREE = 2'd0,
    ST_OWN0 = 2'd1,
    ST_OWN1 = 2'd2,
    ST_OWN2 = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb3_next_state.sv
module arb3_next_state
  import arb3_pkg::*;
(
  input  arb_state_e             cur,
  input  logic [NUM_CLIENTS-1:0] req,
  output arb_state_e             nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_FREE: begin
        if (req[0])      nxt = ST_OWN0;
        else if (req[1]) nxt = ST_OWN1;
        else if (req[2]) nxt = ST_OWN2;
        else             nxt = ST_FREE;
      end
      ST_OWN0: if (!req[0]) nxt = ST_FREE;
      ST_OWN1: if (!req[1]) nxt = ST_FREE;
      ST_OWN2: if (!req[2]) nxt = ST_FREE;
      default: nxt = ST_FREE;
    endcase
  end
endmodule

// File: rtl/arb3_grant_decode.sv
module arb3_grant_decode
  import arb3_pkg::*;
(
  input  arb_state_e             cur,
  output logic [NUM_CLIENTS-1:0] gnt
);
  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : g_dec
    localparam logic [STATE_W-1:0] CODE = STATE_W'(g + 1);
    assign gnt[g] = (cur == arb_state_e'(CODE));
  end
endmodule

// File: rtl/req_arbiter3.sv
module req_arbiter3
  import arb3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req,
  output logic [2:0] gnt
);
  arb_state_e cur_q;
  arb_state_e nxt_c;

  arb3_next_state u_ns (
    .cur (cur_q),
    .req (req),
    .nxt (nxt_c)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur_q <= ST_FREE;
    else     cur_q <= nxt_c;
  end

  arb3_grant_decode u_dec (
    .cur (cur_q),
    .gnt (gnt)
  );

  p_single_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_pick_first_r2: assert property (@(posedge clk) disable iff (rst)
    (gnt == 3'b000 && req[0]) |=> (gnt == 3'b001));

  p_pick_second_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt == 3'b000 && !req[0] && req[1]) |=> (gnt == 3'b010));

  p_pick_third_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt == 3'b000 && req == 3'b100) |=> (gnt == 3'b100));

  p_stay_free_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt == 3'b000 && req == 3'b000) |=> (gnt == 3'b000));

  // R6 and R8: an owner whose request is still up keeps exactly its grant.
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (gnt != 3'b000 && (gnt & req) != 3'b000) |=> (gnt == $past(gnt)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt != 3'b000 && (gnt & req) == 3'b000) |=> (gnt == 3'b000));
endmodule

// File: tb/sim_req_arbiter3.sv
`timescale 1ns/1ps
module sim_req_arbiter3;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = 3'b000;
  logic [2:0] gnt;

  int checks   = 0;
  int failures = 0;
  int owner    = 0;   // 0 free, k = client k-1 owns
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  req_arbiter3 u0 (.clk(clk), .rst(rst), .req(req), .gnt(gnt));

  function automatic logic [2:0] expect_gnt();
    return (owner == 0) ? 3'b000 : (3'b001 << (owner - 1));
  endfunction

  function automatic void model_step(logic [2:0] r);
    if (owner == 0) begin
      if (r[0])      owner = 1;
      else if (r[1]) owner = 2;
      else if (r[2]) owner = 3;
    end else if (!r[owner-1]) begin
      owner = 0;
    end
  endfunction

  task automatic check(logic [2:0] exp, string rq);
    checks++;
    if (gnt !== exp) begin
      failures++;
      $display("FAIL %s gnt=%b expected=%b", rq, gnt, exp);
    end
  endtask

  task automatic cycle(logic [2:0] r, string rq);
    req = r;
    @(posedge clk);
    model_step(r);
    @(negedge clk);
    check(expect_gnt(), rq);
    checks++;
    if ($countones(gnt) > 1) begin
      failures++;
      $display("FAIL R9 gnt=%b expected at most one bit", gnt);
    end
  endtask

  initial begin
    #1;
    check(3'b000, "R1");
    repeat (2) @(negedge clk);
    rst = 1'b0;
    owner = 0;
    repeat (3) cycle(3'b000, "R5");
    cycle(3'b111, "R2");
    for (int i = 0; i < 20; i++) cycle((i % 2) ? 3'b111 : 3'b001, "R6");
    cycle(3'b110, "R7");
    cycle(3'b110, "R3");
    cycle(3'b111, "R8");
    cycle(3'b011, "R8");
    cycle(3'b101, "R7");
    cycle(3'b101, "R2");
    cycle(3'b100, "R7");
    cycle(3'b100, "R4");
    for (int i = 0; i < 50; i++) cycle(3'b100 | 3'(i % 4), "R6");
    cycle(3'b011, "R7");
    cycle(3'b010, "R3");
    cycle(3'b000, "R7");
    cycle(3'b000, "R5");
    // R10: request changes between edges leave the grant alone.
    cycle(3'b001, "R2");
    req = 3'b000;
    #1;
    check(3'b001, "R10");
    req = 3'b001;
    #0.5;
    check(3'b001, "R10");
    cycle(3'b001, "R6");
    // R1: reset in the middle of a grant clears it without a clock edge.
    rst = 1'b1;
    #1;
    check(3'b000, "R1");
    owner = 0;
    @(negedge clk);
    check(3'b000, "R1");
    rst = 1'b0;
    cycle(3'b000, "R5");
    cycle(3'b110, "R3");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule